// File: doc/BRIEF.md
# Prescaled Capture Timer

A 16-bit free-running counter whose clock enable comes from a divider on the bus clock, with two independent input-capture channels. Each channel watches an external line and, on the edge selected for it, copies the counter value into its own 16-bit holding register. It also raises a sticky flag, which can be routed to an interrupt line.

The counter runs up to a programmable terminal value and then returns to zero. On that wrap it sets a sticky wrap flag with its own interrupt enable. Software programs the block through a word-wide write port. The counter, both holding registers and all flags are driven straight out as outputs, so they can be read back without a bus protocol. A stop bit freezes counting and a clear strobe zeroes the count.

Top module: `cap_timer`

## Requirements
- R1: After reset the count, both holding registers and all flags and interrupt outputs are 0. The terminal value is 16'hFFFF, the divide code is 0, counting is running, and all interrupt enables and edge selects are 0.
- R2: Address 0 bits [2:0] hold the divide code. Codes 0..6 advance the counter once every 1, 2, 4, 8, 16, 32 and 64 bus cycles, and code 7 behaves as code 6. Counting starts counting from the cycle after a clear strobe.
- R3: Address 1 holds the terminal value. When the counter advances from the terminal value it goes to 0 and sets the wrap flag.
- R4: Address 0 bit 6 enables the wrap interrupt, and `irq_ovf` is high exactly when the wrap flag and that enable are both set.
- R5: Channel n's settings are at address 2+n. Bits [1:0] select the edge: 00 no capture, 01 rising, 10 falling, 11 both. Edges that are not selected change neither the holding register nor the flag.
- R6: The line is sampled by a two-flop synchronizer. The holding register and flag update on the second clock edge after the edge that first samples the line change. They load the count held just before that update.
- R7: Every selected edge overwrites the holding register, even when the channel flag is already set.
- R8: Channel settings bit 2 enables that channel's interrupt, and `irq_cap[n]` is high exactly when flag n and its enable are set.
- R9: A write to address 4 clears flags where the data has a 1: bit 0 channel 0, bit 1 channel 1, bit 2 wrap. A set event in the same cycle wins over the clear.
- R10: Address 0 bit 4 stops the counter and divider, holding the count. Writing address 0 with bit 5 set zeroes the count and the divider phase in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| cap_in | input | 2 | Capture lines, one per channel |
| count | output | 16 | Current counter value |
| cap0 | output | 16 | Channel 0 holding register |
| cap1 | output | 16 | Channel 1 holding register |
| cap_flag | output | 2 | Channel capture flags |
| ovf_flag | output | 1 | Wrap flag |
| irq_cap | output | 2 | Channel interrupt requests |
| irq_ovf | output | 1 | Wrap interrupt request |

## Verification
The divider is swept through all eight codes over a fixed window from a cleared count. This shows each rate apart and confirms that code 7 repeats the slowest rate. Capture is driven with rising, falling and both-edge selections on lines that move in both directions. A wrong-direction edge and a disabled channel must leave the holding register alone. The exact cycle of each load shows the synchronizer latency. A small terminal value makes wraps frequent, so a clear can be placed on the same edge as a wrap. This separates set-over-clear priority from a plain clear.

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int CW   = 16,
  parameter int DIVW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    cap_in,
  output logic [CW-1:0] count,
  output logic [CW-1:0] cap0,
  output logic [CW-1:0] cap1,
  output logic [1:0]    cap_flag,
  output logic          ovf_flag,
  output logic [1:0]    irq_cap,
  output logic          irq_ovf
);
  localparam logic [2:0] MAX_SHIFT = 3'(DIVW);

  logic [2:0]      ps;
  logic            stop, ovf_ie;
  logic [CW-1:0]   mod;
  logic [1:0]      esel [2];
  logic [1:0]      ch_ie;
  logic [DIVW-1:0] pre;
  logic [1:0]      s1, s2, s3;
  logic [CW-1:0]   cap_r [2];

  wire wr_ctl = wr_en && wr_addr == 3'd0;
  wire wr_clr = wr_en && wr_addr == 3'd4;
  wire cnt_clr = wr_ctl && wr_data[5];
  wire [1:0] clr_cap = wr_clr ? wr_data[1:0] : 2'b00;
  wire clr_ovf = wr_clr && wr_data[2];

  wire [2:0] shift = (ps > MAX_SHIFT) ? MAX_SHIFT : ps;
  wire [DIVW-1:0] mask = ~({DIVW{1'b1}} << shift);
  wire tick = !stop && ((pre & mask) == mask);
  wire ovf_set = tick && count == mod && !cnt_clr;

  wire [1:0] rise = s2 & ~s3;
  wire [1:0] fall = ~s2 & s3;
  logic [1:0] hit;
  always_comb
    for (int i = 0; i < 2; i++)
      hit[i] = (esel[i][0] & rise[i]) | (esel[i][1] & fall[i]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps <= '0; stop <= 1'b0; ovf_ie <= 1'b0; mod <= '1; ch_ie <= '0;
      esel[0] <= '0; esel[1] <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: begin ps <= wr_data[2:0]; stop <= wr_data[4]; ovf_ie <= wr_data[6]; end
        3'd1: mod <= wr_data;
        3'd2: begin esel[0] <= wr_data[1:0]; ch_ie[0] <= wr_data[2]; end
        3'd3: begin esel[1] <= wr_data[1:0]; ch_ie[1] <= wr_data[2]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0; count <= '0; ovf_flag <= 1'b0;
    end else begin
      if (cnt_clr) pre <= '0;
      else if (!stop) pre <= pre + 1'b1;
      if (cnt_clr) count <= '0;
      else if (tick) count <= (count == mod) ? '0 : count + 1'b1;
      ovf_flag <= ovf_set | (ovf_flag & ~clr_ovf);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0; cap_flag <= '0;
      cap_r[0] <= '0; cap_r[1] <= '0;
    end else begin
      s1 <= cap_in; s2 <= s1; s3 <= s2;
      for (int i = 0; i < 2; i++) begin
        if (hit[i]) cap_r[i] <= count;
        cap_flag[i] <= hit[i] | (cap_flag[i] & ~clr_cap[i]);
      end
    end
  end

  assign cap0 = cap_r[0];
  assign cap1 = cap_r[1];
  assign irq_cap = cap_flag & ch_ie;
  assign irq_ovf = ovf_flag & ovf_ie;

  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !cnt_clr) |=> $stable(count));
  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == mod && !cnt_clr) |=> (count == '0 && ovf_flag));
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set && clr_ovf) |=> ovf_flag);
  // R9
  w1c_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !ovf_set) |=> !ovf_flag);
  // R7
  cap0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> (cap0 == $past(count) && cap_flag[0]));
  // R7
  cap1_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit[1] |=> (cap1 == $past(count) && cap_flag[1]));
endmodule

// File: tb/cap_timer_tb.sv
module cap_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0] cap_in = '0;
  logic [15:0] count, cap0, cap1;
  logic [1:0] cap_flag, irq_cap;
  logic ovf_flag, irq_ovf;
  int total = 0, fails = 0;
  logic [15:0] held;

  localparam logic [15:0] RATE_EXP [8] = '{16'd128, 16'd64, 16'd32, 16'd16,
                                          16'd8, 16'd4, 16'd2, 16'd2};

  always #5 clk = ~clk;

  cap_timer u_dut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .cap_in,
                   .count, .cap0, .cap1, .cap_flag, .ovf_flag, .irq_cap, .irq_ovf);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] ctl(input logic [2:0] code, input logic st,
                                      input logic clr, input logic ie);
    return {9'b0, ie, clr, st, 1'b0, code};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 flags", {cap_flag, ovf_flag, irq_cap, irq_ovf}, 0);
    chk("R1 holding", {cap0, cap1}, 0);

    // R2 divide sweep
    for (int i = 0; i < 8; i++) begin
      wr(3'd0, ctl(3'(i), 1'b0, 1'b1, 1'b0));
      wait_n(128);
      chk($sformatf("R2 code %0d", i), count, RATE_EXP[i]);
    end

    // R10 stop holds count
    wr(3'd0, ctl(3'd0, 1'b1, 1'b0, 1'b0));
    held = count;
    wait_n(10);
    chk("R10 stop", count, held);
    wr(3'd1, 16'd3);
    wr(3'd4, 16'h7);
    wr(3'd0, ctl(3'd0, 1'b0, 1'b1, 1'b0));
    chk("R10 clear", count, 0);
    wait_n(3);
    chk("R3 at terminal", {count, 15'b0, ovf_flag}, {16'd3, 16'd0});
    wait_n(1);
    chk("R3 wrap", {count, 15'b0, ovf_flag}, {16'd0, 16'd1});
    chk("R4 gated", irq_ovf, 0);
    wr(3'd0, ctl(3'd0, 1'b0, 1'b0, 1'b1));
    chk("R4 irq", irq_ovf, 1);
    wait_n(2);
    wr(3'd4, 16'h4);
    chk("R9 set wins", {count, 15'b0, ovf_flag}, {16'd0, 16'd1});
    wr(3'd4, 16'h4);
    chk("R9 clear", {ovf_flag, irq_ovf}, 0);

    // capture setup
    wr(3'd0, ctl(3'd0, 1'b1, 1'b0, 1'b0));
    wr(3'd1, 16'hFFFF);
    wr(3'd2, 16'h1);
    wr(3'd3, 16'h6);
    wr(3'd4, 16'h7);
    wr(3'd0, ctl(3'd0, 1'b0, 1'b1, 1'b0));
    wait_n(5);
    cap_in[0] = 1'b1;
    wait_n(2);
    chk("R6 not early", {cap_flag[0], cap0}, 0);
    wait_n(1);
    chk("R6 rising value", cap0, 7);
    chk("R6 flag", cap_flag[0], 1);
    chk("R8 gated", irq_cap[0], 0);
    cap_in[1] = 1'b1;
    wait_n(4);
    chk("R5 rising ignored", {cap_flag[1], cap1}, 0);
    cap_in[1] = 1'b0;
    wait_n(3);
    chk("R5 falling value", cap1, 14);
    chk("R8 irq", irq_cap[1], 1);
    wr(3'd2, 16'h3);
    cap_in[0] = 1'b0;
    wait_n(3);
    chk("R7 overwrite", cap0, 18);
    chk("R7 flag kept", cap_flag[0], 1);
    wr(3'd2, 16'h0);
    cap_in[0] = 1'b1;
    wait_n(4);
    chk("R5 disabled", cap0, 18);
    wr(3'd4, 16'h3);
    chk("R9 cap clear", {cap_flag, irq_cap}, 0);
    finish_run();
  end
endmodule